// File: doc/BRIEF.md
# Ripple Add/Subtract Unit with Dual Overflow Flags

This block is a purely combinational adder/subtractor of parameterised width. A single mode input selects between addition and subtraction; subtraction is realised by complementing the second operand and injecting a carry of one into the lowest stage. The result bits do not depend on whether the caller treats the operands as signed or unsigned. Only the flags interpret them.

The unit reports the raw carry out of the top stage. Alongside it are two range-violation flags, one for the unsigned interpretation and one for the two's-complement interpretation. It also gives a sign bit that tells whether the exact, unbounded result is negative, and that bit remains correct even when the stored result has wrapped. Downstream logic picks whichever flag matches the operand type it is handling.

Top module: `addsub_flags`

## Requirements
- R1: With `sub_en` = 0, `result` equals (`op_a` + `op_b`) modulo 2^WIDTH.
- R2: With `sub_en` = 1, `result` equals (`op_a` − `op_b`) modulo 2^WIDTH. `carry_out` is 1 exactly when `op_a` ≥ `op_b` taken as unsigned values, because the second operand is inverted and the carry-in is forced to 1.
- R3: With `sub_en` = 0, `carry_out` is 1 exactly when the unsigned sum is at least 2^WIDTH.
- R4: `ovf_unsigned` is 1 exactly when the unsigned result lies outside [0, 2^WIDTH − 1]. That is the case for a carry out of 1 in add mode, and for a carry out of 0 in subtract mode.
- R5: `ovf_signed` is 1 exactly when the exact two's-complement result lies outside [−2^(WIDTH−1), 2^(WIDTH−1) − 1]. This equals the XOR of the carries into and out of the top bit.
- R6: `true_sign` is 1 exactly when the exact, unbounded two's-complement result is negative.
- R7: `true_sign` equals `result[WIDTH-1]` when `ovf_signed` is 0, and equals its inverse when `ovf_signed` is 1.
- R8: The following 4-bit cases hold:
  - 1010 + 0110 gives 0000 with `carry_out` = 1 and `ovf_unsigned` = 1.
  - 0110 + 0111 gives 1101 with `ovf_signed` = 1 and `true_sign` = 0.
  - 0111 − 1010 gives `ovf_unsigned` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand (subtrahend in subtract mode) |
| sub_en | input | 1 | 0 = add, 1 = subtract |
| result | output | WIDTH | Sum or difference, wrapped to WIDTH bits |
| carry_out | output | 1 | Carry out of the most significant stage |
| ovf_unsigned | output | 1 | Unsigned range violation |
| ovf_signed | output | 1 | Two's-complement range violation |
| true_sign | output | 1 | Sign of the exact result, valid even when it overflows |

## Verification
The embedded assertions check several relations whenever the inputs change:
- the sign correction against the result MSB and the signed flag;
- the requirement that a signed overflow occur only when the effective operands share a sign and the result's sign differs;
- the agreement between the unsigned flag and a magnitude comparison of the operands;
- the zero result of subtracting equal operands.

Exact arithmetic correctness of every output bit, and the specific worked cases, can only be shown by the bench. It sweeps every operand pair in both modes at 4 bits and compares against integer arithmetic.

// File: rtl/addsub_flags.sv
module addsub_flags #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             sub_en,
  output logic [WIDTH-1:0] result,
  output logic             carry_out,
  output logic             ovf_unsigned,
  output logic             ovf_signed,
  output logic             true_sign
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   cy;

  assign b_eff = op_b ^ {WIDTH{sub_en}};
  assign cy[0] = sub_en;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    assign result[i] = op_a[i] ^ b_eff[i] ^ cy[i];
    assign cy[i+1]   = (op_a[i] & b_eff[i]) | (cy[i] & (op_a[i] ^ b_eff[i]));
  end

  assign carry_out    = cy[WIDTH];
  assign ovf_unsigned = cy[WIDTH] ^ sub_en;
  assign ovf_signed   = cy[WIDTH] ^ cy[MSB];
  assign true_sign    = op_a[MSB] ^ b_eff[MSB] ^ cy[WIDTH];

  always_comb begin
    // R7: corrected sign relative to stored MSB
    a_r7_sign_fix: assert (true_sign == (result[MSB] ^ ovf_signed));
    // R5: signed overflow only when effective operands agree in sign and result differs
    a_r5_sovf_shape: assert (!ovf_signed ||
                             ((op_a[MSB] == b_eff[MSB]) && (result[MSB] != op_a[MSB])));
    // R4: unsigned flag matches magnitude comparison
    a_r4_uovf_mag: assert (ovf_unsigned == (sub_en ? (op_a < op_b) : (result < op_a)));
    // R2: equal operands subtract to zero with carry set
    a_r2_self_sub: assert (!(sub_en && (op_a == op_b)) || ((result == '0) && carry_out));
  end
endmodule

// File: tb/addsub_flags_tb.sv
module addsub_flags_tb;
  localparam int W = 4;
  localparam int M = 1 << W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] a, b, r;
  logic sub, co, ou, os, ts;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  addsub_flags #(.WIDTH(W)) u_dut (
    .op_a(a), .op_b(b), .sub_en(sub), .result(r),
    .carry_out(co), .ovf_unsigned(ou), .ovf_signed(os), .true_sign(ts)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s a=%0d b=%0d sub=%0d actual=%0d expected=%0d", req, a, b, sub, act, exp);
    end
  endtask

  task automatic apply(input int ai, input int bi, input bit s);
    @(negedge clk);
    a = ai[W-1:0]; b = bi[W-1:0]; sub = s;
    @(posedge clk);
    #2;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    a = '0; b = '0; sub = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    #2;
    // R1: idle zero inputs give all-zero outputs
    chk("R1 zero", int'({r, co, ou, os, ts}), 0);

    // R8: worked cases
    apply(4'b1010, 4'b0110, 1'b0);
    chk("R8 r", int'(r), 0); chk("R8 co", int'(co), 1); chk("R8 ou", int'(ou), 1);
    apply(4'b0110, 4'b0111, 1'b0);
    chk("R8 r", int'(r), 13); chk("R8 os", int'(os), 1); chk("R8 ts", int'(ts), 0);
    apply(4'b0111, 4'b1010, 1'b1);
    chk("R8 ou", int'(ou), 1);

    for (int s = 0; s < 2; s++) begin
      for (int ai = 0; ai < M; ai++) begin
        for (int bi = 0; bi < M; bi++) begin
          int full, sa, sb, sx;
          apply(ai, bi, s[0]);
          sa = (ai >= M/2) ? ai - M : ai;
          sb = (bi >= M/2) ? bi - M : bi;
          if (s == 0) begin
            full = ai + bi;
            sx = sa + sb;
            chk("R1 result", int'(r), full % M);
            chk("R3 carry", int'(co), int'(full >= M));
            chk("R4 uovf", int'(ou), int'(full >= M));
          end else begin
            full = ai - bi + M;
            sx = sa - sb;
            chk("R2 result", int'(r), full % M);
            chk("R2 carry", int'(co), int'(ai >= bi));
            chk("R4 uovf", int'(ou), int'(ai < bi));
          end
          chk("R5 sovf", int'(os), int'((sx < -(M/2)) || (sx > M/2 - 1)));
          chk("R6 sign", int'(ts), int'(sx < 0));
          chk("R7 msbfix", int'(ts), int'(r[W-1] ^ os));
        end
      end
    end
    finish_run();
  end
endmodule